// File: doc/BRIEF.md
# Serial Adapter Host Register and Interrupt Block

This block is the processor-facing half of an asynchronous serial adapter. A host reaches it through a chip select, a two-bit register select, a read/write line and a one-cycle access strobe. Through these it writes transmit characters, reads received characters, reads a status byte, and reads or writes a command byte and a line-control byte. The serializer and deserializer sit outside the block. They report through pulse inputs: a character was received (with its framing and parity results), or the transmit holding byte was taken. The block hands them the holding byte and the line configuration.

The block decides when the host must be interrupted, and drives an active-low interrupt line. It watches the two modem status inputs, data-set-ready and carrier-detect, through a synchronizer. When either input changes, it latches the new levels and raises an interrupt. It then freezes those status bits until the host has read status. Two kinds of reset exist. The synchronous `rst` input clears everything. A write to the status address is a soft reset: it clears only the low command bits and the overrun flag, and it withdraws only a pending modem interrupt. The block also drives the terminal-ready and request-to-send outputs from the command byte.

Top module: `sa_hostregs`

## Requirements
- R1: After `rst`, the command and control bytes read 0x00. The status byte reads with bit 4 (transmit holding empty) set and bits 7, 3, 2, 1 and 0 clear. Bits 6 and 5 follow the inverted-logic pins `dsr_n` and `dcd_n`. `dtr_n`, `rts_n` and `irq_n` are high.
- R2: Register select {rs[1],rs[0]} works as follows. 00 writes the transmit byte and reads the receive byte. 01 reads status. 10 accesses the command byte. 11 accesses the control byte. A transmit write appears on `tx_data` and clears status bit 4. A `tx_taken` pulse sets status bit 4 again.
- R3: A `rx_done` pulse with the receive byte empty has four effects. It loads `rx_byte` into the receive byte, sets status bit 3, and copies `rx_frame_err` to bit 1 and `rx_parity_err` to bit 0. Reading the receive byte clears bits 3, 2, 1 and 0.
- R4: A `rx_done` pulse while status bit 3 is set leaves the receive byte unchanged and sets status bit 2 (overrun).
- R5: Status bit 7 is set when any enabled interrupt cause occurs, and a status read clears it. `irq_n` is low exactly while bit 7 is set.
- R6: A character load raises an interrupt only when command bit 0 is 1 and command bit 1 is 0.
- R7: A `tx_taken` pulse raises an interrupt only when command bit 0 is 1 and command bits 3:2 are 01.
- R8: With command bit 0 set, a change on `dsr_n` or `dcd_n` does three things: it raises an interrupt, latches the new levels into status bits 6 and 5, and freezes those bits. A status read releases the freeze. If a pin then differs from its latched bit, a new interrupt follows within two cycles.
- R9: `dtr_n` is the inverse of command bit 0. `rts_n` is high only when command bits 3:2 are 00 and command bit 4 (echo) is 0. `tx_break` is high when command bits 3:2 are 11 with command bit 0 set and echo off.
- R10: A write to select 01 has five effects. It clears command bits 4:0 and status bit 2, keeps command bits 7:5 and the control byte, and drives `dtr_n` high. It withdraws a pending modem interrupt but keeps a pending receive or transmit interrupt.
- R11: With command bit 0 clear, no cause raises an interrupt. Status bits 6 and 5 then track the pins without freezing.
- R12: An access with `sel` low or `strobe` low changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| sel | input | 1 | Chip select |
| strobe | input | 1 | One-cycle access strobe |
| rd_wr | input | 1 | 1 = read, 0 = write |
| rs | input | 2 | Register select |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data (0 when not a selected read) |
| rx_done | input | 1 | Deserializer finished a character |
| rx_byte | input | 8 | Received character |
| rx_frame_err | input | 1 | Framing error of that character |
| rx_parity_err | input | 1 | Parity error of that character |
| tx_taken | input | 1 | Serializer took the holding byte |
| tx_data | output | 8 | Transmit holding byte |
| dsr_n | input | 1 | Data-set-ready pin, active low |
| dcd_n | input | 1 | Carrier-detect pin, active low |
| dtr_n | output | 1 | Terminal-ready pin, active low |
| rts_n | output | 1 | Request-to-send pin, active low |
| irq_n | output | 1 | Interrupt request, active low |
| tx_enable | output | 1 | Transmitter allowed to run |
| rx_enable | output | 1 | Receiver allowed to run |
| tx_break | output | 1 | Send continuous break |
| echo_on | output | 1 | Echo mode selected |
| line_cfg | output | 8 | Control byte for the datapath |
| parity_cfg | output | 3 | Command bits 7:5 for the datapath |

## Verification
The bench targets the modem freeze. It changes a pin back while the bits are frozen, and checks that the status read still shows the old level and that a second interrupt follows the read. A design that tracked the pins freely would show the new level early and miss that interrupt. The bench overruns the receive byte and checks that the first character survives. A design that overwrote it would return the second byte. It issues a soft reset while a transmit interrupt is pending and, separately, while a modem interrupt is pending. This catches a design that clears both interrupt kinds or neither, or one that disturbs the control byte. It also drives every cause with command bit 0 clear, which catches any path that ignores the master enable.

// File: rtl/sa_hostregs_pkg.sv
package sa_hostregs_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        RSEL_DATA = 2'b00,
        RSEL_STAT = 2'b01,
        RSEL_CMD  = 2'b10,
        RSEL_CTL  = 2'b11
    } rsel_e;

    typedef enum logic [1:0] {
        TXM_OFF   = 2'b00,
        TXM_IRQ   = 2'b01,
        TXM_QUIET = 2'b10,
        TXM_BREAK = 2'b11
    } txmode_e;

    typedef struct packed {
        logic wr_tx;
        logic rd_rx;
        logic wr_prst;
        logic rd_stat;
        logic wr_cmd;
        logic wr_ctl;
    } access_t;

    typedef struct packed {
        logic irq;
        logic dsr;
        logic dcd;
        logic tdre;
        logic rdrf;
        logic ovr;
        logic fe;
        logic pe;
    } status_t;

    typedef struct packed {
        logic [2:0] parity;
        logic       echo;
        txmode_e    txmode;
        logic       rx_mask;
        logic       ready;
    } cmd_t;

    function automatic logic rts_level(input cmd_t c);
        return !(c.echo || (c.txmode != TXM_OFF));
    endfunction

endpackage

// File: rtl/sa_access_dec.sv
module sa_access_dec
    import sa_hostregs_pkg::*;
(
    input  logic       sel,
    input  logic       strobe,
    input  logic       rd_wr,
    input  logic [1:0] rs,
    output access_t    acc
);
    logic  live;
    rsel_e which;

    assign live  = sel && strobe;
    assign which = rsel_e'(rs);

    always_comb begin
        acc = '0;
        if (live) begin
            unique case (which)
                RSEL_DATA: begin
                    acc.wr_tx = !rd_wr;
                    acc.rd_rx = rd_wr;
                end
                RSEL_STAT: begin
                    acc.wr_prst = !rd_wr;
                    acc.rd_stat = rd_wr;
                end
                RSEL_CMD:  acc.wr_cmd = !rd_wr;
                RSEL_CTL:  acc.wr_ctl = !rd_wr;
                default:   acc = '0;
            endcase
        end
    end
endmodule

// File: rtl/sa_modem_watch.sv
module sa_modem_watch #(
    parameter int SYNC_STAGES = 2,
    parameter int LINES       = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LINES-1:0] pins,
    input  logic             enable,
    input  logic             unfreeze,
    output logic [LINES-1:0] lvl,
    output logic             event_o,
    output logic             frozen
);
    logic [SYNC_STAGES-1:0][LINES-1:0] stg;
    logic [LINES-1:0]                  settled;
    logic [LINES-1:0]                  lvl_q;
    logic                              frozen_q;
    logic                              differs;

    assign settled = stg[SYNC_STAGES-1];
    assign differs = (settled != lvl_q) && !frozen_q;
    assign event_o = differs && enable;
    assign lvl     = lvl_q;
    assign frozen  = frozen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stg <= '1;
        end else begin
            stg[0] <= pins;
            for (int i = 1; i < SYNC_STAGES; i++) begin
                stg[i] <= stg[i-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q    <= '1;
            frozen_q <= 1'b0;
        end else begin
            if (differs) lvl_q <= settled;
            if (event_o)       frozen_q <= 1'b1;
            else if (unfreeze) frozen_q <= 1'b0;
        end
    end
endmodule

// File: rtl/sa_irq_ctrl.sv
module sa_irq_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic en_all,
    input  logic en_rx,
    input  logic en_tx,
    input  logic modem_evt,
    input  logic rx_evt,
    input  logic tx_evt,
    input  logic stat_rd,
    input  logic prst,
    output logic irq_modem,
    output logic irq_rxtx
);
    logic set_modem;
    logic set_rxtx;

    assign set_modem = modem_evt;
    assign set_rxtx  = en_all && ((rx_evt && en_rx) || (tx_evt && en_tx));

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_modem <= 1'b0;
            irq_rxtx  <= 1'b0;
        end else begin
            if (set_modem)              irq_modem <= 1'b1;
            else if (stat_rd || prst)   irq_modem <= 1'b0;
            if (set_rxtx)               irq_rxtx  <= 1'b1;
            else if (stat_rd)           irq_rxtx  <= 1'b0;
        end
    end
endmodule

// File: rtl/sa_hostregs.sv
module sa_hostregs
    import sa_hostregs_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel,
    input  logic              strobe,
    input  logic              rd_wr,
    input  logic [1:0]        rs,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    input  logic              rx_done,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              rx_frame_err,
    input  logic              rx_parity_err,
    input  logic              tx_taken,
    output logic [BYTE_W-1:0] tx_data,
    input  logic              dsr_n,
    input  logic              dcd_n,
    output logic              dtr_n,
    output logic              rts_n,
    output logic              irq_n,
    output logic              tx_enable,
    output logic              rx_enable,
    output logic              tx_break,
    output logic              echo_on,
    output logic [BYTE_W-1:0] line_cfg,
    output logic [2:0]        parity_cfg
);
    access_t           acc;
    cmd_t              cmd_q;
    logic [BYTE_W-1:0] ctl_q;
    logic [BYTE_W-1:0] tdr_q;
    logic [BYTE_W-1:0] rdr_q;
    logic              tdre_q, rdrf_q, ovr_q, fe_q, pe_q;
    logic [1:0]        lvl;
    logic              modem_evt, frozen;
    logic              irq_modem, irq_rxtx;
    logic              rx_load, rx_clash;
    status_t           stat;

    sa_access_dec u_dec (
        .sel    (sel),
        .strobe (strobe),
        .rd_wr  (rd_wr),
        .rs     (rs),
        .acc    (acc)
    );

    sa_modem_watch #(.SYNC_STAGES(SYNC_STAGES), .LINES(2)) u_modem (
        .clk      (clk),
        .rst      (rst),
        .pins     ({dsr_n, dcd_n}),
        .enable   (cmd_q.ready),
        .unfreeze (acc.rd_stat || acc.wr_prst),
        .lvl      (lvl),
        .event_o  (modem_evt),
        .frozen   (frozen)
    );

    assign rx_clash = rdrf_q && !acc.rd_rx;
    assign rx_load  = rx_done && !rx_clash;

    sa_irq_ctrl u_irq (
        .clk       (clk),
        .rst       (rst),
        .en_all    (cmd_q.ready),
        .en_rx     (!cmd_q.rx_mask),
        .en_tx     (cmd_q.txmode == TXM_IRQ),
        .modem_evt (modem_evt),
        .rx_evt    (rx_load),
        .tx_evt    (tx_taken),
        .stat_rd   (acc.rd_stat),
        .prst      (acc.wr_prst),
        .irq_modem (irq_modem),
        .irq_rxtx  (irq_rxtx)
    );

    // command and control bytes
    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= '0;
            ctl_q <= '0;
        end else begin
            if (acc.wr_cmd)       cmd_q <= cmd_t'(wdata);
            else if (acc.wr_prst) cmd_q <= cmd_t'({cmd_q.parity, 5'b0});
            if (acc.wr_ctl)       ctl_q <= wdata;
        end
    end

    // transmit holding byte
    always_ff @(posedge clk) begin
        if (rst) begin
            tdr_q  <= '0;
            tdre_q <= 1'b1;
        end else begin
            if (tx_taken)  tdre_q <= 1'b1;
            if (acc.wr_tx) begin
                tdr_q  <= wdata;
                tdre_q <= 1'b0;
            end
        end
    end

    // receive byte and error flags
    always_ff @(posedge clk) begin
        if (rst) begin
            rdr_q  <= '0;
            rdrf_q <= 1'b0;
            ovr_q  <= 1'b0;
            fe_q   <= 1'b0;
            pe_q   <= 1'b0;
        end else begin
            if (acc.rd_rx) begin
                rdrf_q <= 1'b0;
                ovr_q  <= 1'b0;
                fe_q   <= 1'b0;
                pe_q   <= 1'b0;
            end
            if (acc.wr_prst) ovr_q <= 1'b0;
            if (rx_done) begin
                if (rx_clash) begin
                    ovr_q <= 1'b1;
                end else begin
                    rdr_q  <= rx_byte;
                    rdrf_q <= 1'b1;
                    fe_q   <= rx_frame_err;
                    pe_q   <= rx_parity_err;
                end
            end
        end
    end

    always_comb begin
        stat.irq  = irq_modem || irq_rxtx;
        stat.dsr  = lvl[1];
        stat.dcd  = lvl[0];
        stat.tdre = tdre_q;
        stat.rdrf = rdrf_q;
        stat.ovr  = ovr_q;
        stat.fe   = fe_q;
        stat.pe   = pe_q;
    end

    always_comb begin
        rdata = '0;
        if (sel && rd_wr) begin
            unique case (rsel_e'(rs))
                RSEL_DATA: rdata = rdr_q;
                RSEL_STAT: rdata = stat;
                RSEL_CMD:  rdata = cmd_q;
                RSEL_CTL:  rdata = ctl_q;
                default:   rdata = '0;
            endcase
        end
    end

    assign tx_data    = tdr_q;
    assign dtr_n      = !cmd_q.ready;
    assign rts_n      = rts_level(cmd_q);
    assign irq_n      = !stat.irq;
    assign echo_on    = cmd_q.echo;
    assign tx_enable  = cmd_q.ready && (cmd_q.echo || cmd_q.txmode != TXM_OFF);
    assign rx_enable  = cmd_q.ready;
    assign tx_break   = cmd_q.ready && !cmd_q.echo && (cmd_q.txmode == TXM_BREAK);
    assign line_cfg   = ctl_q;
    assign parity_cfg = cmd_q.parity;
endmodule

// File: rtl/sa_hostregs_chk.sv
module sa_hostregs_chk (
    input logic       clk,
    input logic       rst,
    input logic       acc_prst,
    input logic       acc_rd_stat,
    input logic       acc_rd_rx,
    input logic       rx_done,
    input logic       tx_taken,
    input logic       rdrf_q,
    input logic       ovr_q,
    input logic [7:0] rdr_q,
    input logic       irq_rxtx,
    input logic [7:0] cmd_q,
    input logic [7:0] ctl_q,
    input logic       frozen,
    input logic [1:0] lvl,
    input logic       dtr_n,
    input logic       rts_n,
    input logic       irq_n
);
    assert_reset_pins_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (dtr_n && rts_n && irq_n));

    assert_overrun_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (rx_done && rdrf_q && !acc_rd_rx) |=> (ovr_q && $stable(rdr_q)));

    assert_stat_clear_R5: assert property (@(posedge clk) disable iff (rst)
        (acc_rd_stat && !rx_done && !tx_taken) |=> !irq_rxtx);

    assert_freeze_R8: assert property (@(posedge clk) disable iff (rst)
        (frozen && !acc_rd_stat && !acc_prst) |=> $stable(lvl));

    assert_prst_R10: assert property (@(posedge clk) disable iff (rst)
        acc_prst |=> ((cmd_q[4:0] == 5'd0) && dtr_n && $stable(ctl_q)));

    assert_silent_R11: assert property (@(posedge clk) disable iff (rst)
        (!cmd_q[0] && irq_n) |=> irq_n);
endmodule

bind sa_hostregs sa_hostregs_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .acc_prst    (acc.wr_prst),
    .acc_rd_stat (acc.rd_stat),
    .acc_rd_rx   (acc.rd_rx),
    .rx_done     (rx_done),
    .tx_taken    (tx_taken),
    .rdrf_q      (rdrf_q),
    .ovr_q       (ovr_q),
    .rdr_q       (rdr_q),
    .irq_rxtx    (irq_rxtx),
    .cmd_q       (cmd_q),
    .ctl_q       (ctl_q),
    .frozen      (frozen),
    .lvl         (lvl),
    .dtr_n       (dtr_n),
    .rts_n       (rts_n),
    .irq_n       (irq_n)
);

// File: tb/test_sa_hostregs.sv
module test_sa_hostregs;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sel = 1'b0, strobe = 1'b0, rd_wr = 1'b0;
    logic [1:0] rs = 2'b00;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       rx_done = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       rx_frame_err = 1'b0, rx_parity_err = 1'b0;
    logic       tx_taken = 1'b0;
    logic [7:0] tx_data;
    logic       dsr_n = 1'b0, dcd_n = 1'b1;
    logic       dtr_n, rts_n, irq_n;
    logic       tx_enable, rx_enable, tx_break, echo_on;
    logic [7:0] line_cfg;
    logic [2:0] parity_cfg;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    sa_hostregs i_sa_hostregs (
        .clk(clk), .rst(rst), .sel(sel), .strobe(strobe), .rd_wr(rd_wr),
        .rs(rs), .wdata(wdata), .rdata(rdata), .rx_done(rx_done),
        .rx_byte(rx_byte), .rx_frame_err(rx_frame_err),
        .rx_parity_err(rx_parity_err), .tx_taken(tx_taken),
        .tx_data(tx_data), .dsr_n(dsr_n), .dcd_n(dcd_n), .dtr_n(dtr_n),
        .rts_n(rts_n), .irq_n(irq_n), .tx_enable(tx_enable),
        .rx_enable(rx_enable), .tx_break(tx_break), .echo_on(echo_on),
        .line_cfg(line_cfg), .parity_cfg(parity_cfg)
    );

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        sel = 1'b1; strobe = 1'b1; rd_wr = 1'b0; rs = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; strobe = 1'b0;
    endtask

    task automatic do_rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        sel = 1'b1; strobe = 1'b1; rd_wr = 1'b1; rs = a;
        #1 d = rdata;
        @(negedge clk);
        sel = 1'b0; strobe = 1'b0; rd_wr = 1'b0;
    endtask

    task automatic rx_char(input logic [7:0] b, input logic f, input logic p);
        @(negedge clk);
        rx_done = 1'b1; rx_byte = b; rx_frame_err = f; rx_parity_err = p;
        @(negedge clk);
        rx_done = 1'b0; rx_frame_err = 1'b0; rx_parity_err = 1'b0;
    endtask

    task automatic tx_take();
        @(negedge clk);
        tx_taken = 1'b1;
        @(negedge clk);
        tx_taken = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        do_rd(2'b01, v); check("R1", "status after reset", v, 8'h30);
        do_rd(2'b10, v); check("R1", "command after reset", v, 8'h00);
        do_rd(2'b11, v); check("R1", "control after reset", v, 8'h00);
        check("R1", "pins dtr/rts/irq", {5'b0, dtr_n, rts_n, irq_n}, 8'h07);
    endtask

    task automatic t_regmap();
        logic [7:0] v;
        do_wr(2'b11, 8'hA5); do_rd(2'b11, v); check("R2", "control readback", v, 8'hA5);
        do_wr(2'b10, 8'hE0); do_rd(2'b10, v); check("R2", "command readback", v, 8'hE0);
        // R12: write without chip select, then without strobe
        @(negedge clk); sel = 1'b0; strobe = 1'b1; rd_wr = 1'b0; rs = 2'b11; wdata = 8'hFF;
        @(negedge clk); sel = 1'b1; strobe = 1'b0;
        @(negedge clk); sel = 1'b0;
        do_rd(2'b11, v); check("R12", "control untouched", v, 8'hA5);
        do_wr(2'b00, 8'h3C);
        check("R2", "tx_data", tx_data, 8'h3C);
        do_rd(2'b01, v); check("R2", "status tdre cleared", v, 8'h20);
        tx_take();
        do_rd(2'b01, v); check("R2", "status tdre set by take", v, 8'h30);
    endtask

    task automatic t_txirq();
        logic [7:0] v;
        do_wr(2'b10, 8'h05);
        do_wr(2'b00, 8'h81);
        check("R2", "tx_data second", tx_data, 8'h81);
        tx_take();
        check("R7", "irq_n after take", {7'b0, irq_n}, 8'h00);
        do_rd(2'b01, v); check("R5", "status with irq", v, 8'hB0);
        check("R5", "irq_n after status read", {7'b0, irq_n}, 8'h01);
        do_wr(2'b10, 8'h09);
        do_wr(2'b00, 8'h11);
        tx_take();
        check("R7", "irq_n tx irq off", {7'b0, irq_n}, 8'h01);
        do_rd(2'b01, v); check("R7", "status tx irq off", v, 8'h30);
    endtask

    task automatic t_rx();
        logic [7:0] v;
        do_wr(2'b10, 8'h01);
        rx_char(8'h5A, 1'b1, 1'b0);
        check("R6", "irq_n after rx load", {7'b0, irq_n}, 8'h00);
        do_rd(2'b01, v); check("R3", "status after rx", v, 8'hBA);
        do_rd(2'b00, v); check("R3", "receive byte", v, 8'h5A);
        do_rd(2'b01, v); check("R3", "status after rx read", v, 8'h30);
        rx_char(8'h11, 1'b0, 1'b0);
        rx_char(8'h22, 1'b0, 1'b0);
        do_rd(2'b01, v); check("R4", "status overrun", v, 8'hBC);
        do_rd(2'b00, v); check("R4", "first byte kept", v, 8'h11);
        do_rd(2'b01, v); check("R4", "overrun cleared by data read", v, 8'h30);
        do_wr(2'b10, 8'h03);
        rx_char(8'h44, 1'b0, 1'b1);
        check("R6", "irq_n rx masked", {7'b0, irq_n}, 8'h01);
        do_rd(2'b01, v); check("R6", "status rx masked", v, 8'h39);
        do_rd(2'b00, v); check("R3", "masked byte", v, 8'h44);
    endtask

    task automatic t_modem();
        logic [7:0] v;
        do_wr(2'b10, 8'h01);
        @(negedge clk); dcd_n = 1'b0;
        wait_cyc(4);
        check("R8", "irq_n on dcd change", {7'b0, irq_n}, 8'h00);
        @(negedge clk); dcd_n = 1'b1;
        wait_cyc(4);
        do_rd(2'b01, v); check("R8", "status frozen dcd", v, 8'h90);
        wait_cyc(2);
        check("R8", "irq_n re-raised", {7'b0, irq_n}, 8'h00);
        do_rd(2'b01, v); check("R8", "status new dcd", v, 8'hB0);
        wait_cyc(3);
        check("R8", "irq_n quiet after", {7'b0, irq_n}, 8'h01);
    endtask

    task automatic t_pins();
        do_wr(2'b10, 8'h00);
        check("R9", "cmd00 dtr/rts/brk", {5'b0, dtr_n, rts_n, tx_break}, 8'h06);
        do_wr(2'b10, 8'h01);
        check("R9", "cmd01 dtr/rts/brk", {5'b0, dtr_n, rts_n, tx_break}, 8'h02);
        do_wr(2'b10, 8'h05);
        check("R9", "cmd05 dtr/rts/brk", {5'b0, dtr_n, rts_n, tx_break}, 8'h00);
        do_wr(2'b10, 8'h0D);
        check("R9", "cmd0D dtr/rts/brk", {5'b0, dtr_n, rts_n, tx_break}, 8'h01);
        do_wr(2'b10, 8'h11);
        check("R9", "echo rts/brk/echo", {5'b0, rts_n, tx_break, echo_on}, 8'h01);
    endtask

    task automatic t_prst();
        logic [7:0] v;
        do_wr(2'b11, 8'h5B);
        do_wr(2'b10, 8'hE5);
        tx_take();
        check("R7", "irq_n before soft reset", {7'b0, irq_n}, 8'h00);
        do_wr(2'b01, 8'h00);
        do_rd(2'b10, v); check("R10", "command after soft reset", v, 8'hE0);
        do_rd(2'b11, v); check("R10", "control kept", v, 8'h5B);
        check("R10", "dtr_n and tx irq kept", {6'b0, dtr_n, irq_n}, 8'h02);
        do_rd(2'b01, v); check("R10", "status pending tx", v, 8'hB0);
        do_wr(2'b10, 8'h01);
        rx_char(8'h66, 1'b0, 1'b0);
        rx_char(8'h77, 1'b0, 1'b0);
        do_rd(2'b01, v); check("R4", "overrun before soft reset", v, 8'hBC);
        @(negedge clk); dsr_n = 1'b1;
        wait_cyc(4);
        check("R8", "irq_n on dsr change", {7'b0, irq_n}, 8'h00);
        do_wr(2'b01, 8'h00);
        check("R10", "modem irq withdrawn", {7'b0, irq_n}, 8'h01);
        do_rd(2'b01, v); check("R10", "overrun cleared", v, 8'h78);
        do_rd(2'b00, v); check("R10", "byte survives", v, 8'h66);
    endtask

    task automatic t_disabled();
        logic [7:0] v;
        rx_char(8'h55, 1'b0, 1'b0);
        tx_take();
        check("R11", "irq_n rx/tx disabled", {7'b0, irq_n}, 8'h01);
        @(negedge clk); dcd_n = 1'b0;
        wait_cyc(4);
        do_rd(2'b01, v); check("R11", "dcd tracks low", v, 8'h58);
        @(negedge clk); dcd_n = 1'b1;
        wait_cyc(4);
        do_rd(2'b01, v); check("R11", "dcd tracks high", v, 8'h78);
        check("R11", "irq_n modem disabled", {7'b0, irq_n}, 8'h01);
        do_rd(2'b00, v); check("R11", "byte loaded while disabled", v, 8'h55);
    endtask

    initial begin
        wait_cyc(3);
        rst = 1'b0;
        wait_cyc(5);
        t_reset();
        t_regmap();
        t_txirq();
        t_rx();
        t_modem();
        t_pins();
        t_prst();
        t_disabled();
        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        for (int i = 0; i < 20000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule